// File: doc/BRIEF.md
# Stretched Low-Resolution Framebuffer Pixel Fetch

This block sits between a raster sync generator and an external byte-wide image memory. Each clock it takes the current horizontal clock count, the current line count and the two active-region flags. It turns the counts into the memory address of a 100 x 75 pixel image. The image is stretched to cover a visible window of 200 clocks by 600 lines. Two neighbouring clocks show the same stored pixel, and eight neighbouring lines show the same stored row. The memory output-enable is driven only while the beam is inside the visible window.

The memory gets one clock to answer. The address and output-enable are registered from the counts. On the following edge, the returned byte is unpacked into three 2-bit channel codes. The delayed display-enable travels with the address. Whenever that enable is low, the colour register loads black, so stale or floating memory data never reaches the screen during blanking. The digital-to-analog stage that turns each 2-bit code into one of four intensity levels is outside this block.

Top module: `lowres_pixel_fetch`

## Requirements
- R1: While reset is asserted, and on the first edge after it, the address is 0, output-enable is 0 and all three channel codes are 0.
- R2: One clock after a horizontal count h is presented, address bits [6:0] hold h divided by 2 (rounded down).
- R3: One clock after a line count v is presented, address bits [13:7] hold v divided by 8 (rounded down), so the address equals 128 * floor(v/8) + floor(h/2).
- R4: One clock after the inputs, output-enable is 1 exactly when both the horizontal and the vertical active flags were 1. Otherwise it is 0.
- R5: Two clocks after the inputs of an active position, the colour outputs show the byte read from that position's address. Red is byte bits [5:4], green is bits [3:2] and blue is bits [1:0]. Byte bits [7:6] have no effect on any output.
- R6: Two clocks after the inputs of a blanked position (either flag 0), all three channel codes are 00, whatever the memory returns.
- R7: Stretching holds in both directions. Horizontal counts 2k and 2k+1 give the same address. Lines 8j through 8j+7 give the same row index.
- R8: The corners of the visible window map onto the image corners. Count (0,0) gives address 0. Count (199,599) gives pixel column 99 of row 74, address 9571.
- R9: The pipeline is fully streamed. A new position is accepted every clock, and each output relates only to the inputs of its own position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_count | input | 9 | Horizontal clock count from the sync generator |
| v_count | input | 10 | Line count from the sync generator |
| h_active | input | 1 | High inside the horizontal visible region |
| v_active | input | 1 | High inside the vertical visible region |
| mem_rdata | input | 8 | Byte returned by the image memory |
| mem_addr | output | 14 | Image memory address, {row[6:0], column[6:0]} |
| mem_oe | output | 1 | Image memory output-enable, high only in active video |
| red | output | 2 | Red channel intensity code |
| green | output | 2 | Green channel intensity code |
| blue | output | 2 | Blue channel intensity code |

## Verification
The bound checker looks at every clock. It checks the per-cycle relations between inputs and outputs: the address fields one clock behind the counts, output-enable one clock behind the flags, the colour one clock behind the returned byte when enabled, and black one clock after a disabled cycle. Some behaviour only the bench scenarios can show. Stretching across neighbouring clocks and lines needs known images. So do the exact corner addresses and the fact that the top two bits of the byte are ignored. A streamed line where active video ends partway through shows that positions do not leak into each other across the two pipeline stages.

// File: rtl/pf_pkg.sv
package pf_pkg;

  localparam int PIX_COORD_W = 7;
  localparam int PIX_BYTE_W  = 8;
  localparam int CH_W        = 2;
  localparam int COLOUR_W    = 3 * CH_W;
  localparam int ADDR_W      = 2 * PIX_COORD_W;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

  localparam rgb_t RGB_BLACK = '{r: '0, g: '0, b: '0};

  // Row index occupies the upper half of the address, column the lower.
  function automatic logic [ADDR_W-1:0] join_addr(
    input logic [PIX_COORD_W-1:0] row,
    input logic [PIX_COORD_W-1:0] col
  );
    return {row, col};
  endfunction

  // Colour bits of a stored byte: red high, then green, then blue low.
  function automatic rgb_t unpack_rgb(input logic [COLOUR_W-1:0] bits);
    rgb_t c;
    c.r = bits[3*CH_W-1 -: CH_W];
    c.g = bits[2*CH_W-1 -: CH_W];
    c.b = bits[CH_W-1   -: CH_W];
    return c;
  endfunction

endpackage

// File: rtl/pf_coord_map.sv
module pf_coord_map
  import pf_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int SHIFT = 1
) (
  input  logic [CNT_W-1:0]       count,
  output logic [PIX_COORD_W-1:0] index
);

  localparam int STRETCH = 1 << SHIFT;

  logic [CNT_W-1:0] scaled;

  // Each stored pixel covers STRETCH consecutive counts.
  assign scaled = count >> SHIFT;

  generate
    if (CNT_W > PIX_COORD_W) begin : g_trim
      logic unused_hi;
      assign unused_hi = ^scaled[CNT_W-1:PIX_COORD_W];
      assign index     = scaled[PIX_COORD_W-1:0];
    end else begin : g_pad
      assign index = PIX_COORD_W'(scaled);
    end
  endgenerate

endmodule

// File: rtl/pf_addr_stage.sv
module pf_addr_stage
  import pf_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PIX_COORD_W-1:0] col_idx,
  input  logic [PIX_COORD_W-1:0] row_idx,
  input  logic                   de_now,
  output logic [ADDR_W-1:0]      addr_q,
  output logic                   de_q
);

  logic [ADDR_W-1:0] addr_next;

  assign addr_next = join_addr(row_idx, col_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      de_q   <= 1'b0;
    end else begin
      addr_q <= addr_next;
      de_q   <= de_now;
    end
  end

endmodule

// File: rtl/pf_colour_stage.sv
module pf_colour_stage
  import pf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  de_q,
  input  logic [PIX_BYTE_W-1:0] rdata,
  output rgb_t                  rgb_q
);

  logic [COLOUR_W-1:0] colour_bits;
  logic                unused_pad;
  rgb_t                rgb_next;

  assign colour_bits = rdata[COLOUR_W-1:0];
  assign unused_pad  = ^rdata[PIX_BYTE_W-1:COLOUR_W];

  // Blanking wins over any data the memory bus may carry.
  assign rgb_next = de_q ? unpack_rgb(colour_bits) : RGB_BLACK;

  always_ff @(posedge clk) begin
    if (!rst_n) rgb_q <= RGB_BLACK;
    else        rgb_q <= rgb_next;
  end

endmodule

// File: rtl/lowres_pixel_fetch.sv
module lowres_pixel_fetch
  import pf_pkg::*;
#(
  parameter int H_CNT_W = 9,
  parameter int V_CNT_W = 10,
  parameter int H_SHIFT = 1,
  parameter int V_SHIFT = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [H_CNT_W-1:0]     h_count,
  input  logic [V_CNT_W-1:0]     v_count,
  input  logic                   h_active,
  input  logic                   v_active,
  input  logic [PIX_BYTE_W-1:0]  mem_rdata,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic                   mem_oe,
  output logic [CH_W-1:0]        red,
  output logic [CH_W-1:0]        green,
  output logic [CH_W-1:0]        blue
);

  logic [PIX_COORD_W-1:0] col_idx;
  logic [PIX_COORD_W-1:0] row_idx;
  logic                   de_now;
  logic                   de_q;
  rgb_t                   rgb_q;

  assign de_now = h_active & v_active;

  pf_coord_map #(.CNT_W(H_CNT_W), .SHIFT(H_SHIFT)) u_col (
    .count (h_count),
    .index (col_idx)
  );

  pf_coord_map #(.CNT_W(V_CNT_W), .SHIFT(V_SHIFT)) u_row (
    .count (v_count),
    .index (row_idx)
  );

  pf_addr_stage u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .col_idx (col_idx),
    .row_idx (row_idx),
    .de_now  (de_now),
    .addr_q  (mem_addr),
    .de_q    (de_q)
  );

  pf_colour_stage u_colour (
    .clk   (clk),
    .rst_n (rst_n),
    .de_q  (de_q),
    .rdata (mem_rdata),
    .rgb_q (rgb_q)
  );

  assign mem_oe = de_q;
  assign red    = rgb_q.r;
  assign green  = rgb_q.g;
  assign blue   = rgb_q.b;

endmodule

// File: rtl/pf_checker.sv
module pf_checker
  import pf_pkg::*;
#(
  parameter int H_CNT_W = 9,
  parameter int V_CNT_W = 10,
  parameter int H_SHIFT = 1,
  parameter int V_SHIFT = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [H_CNT_W-1:0]    h_count,
  input logic [V_CNT_W-1:0]    v_count,
  input logic                  h_active,
  input logic                  v_active,
  input logic [PIX_BYTE_W-1:0] mem_rdata,
  input logic [ADDR_W-1:0]     mem_addr,
  input logic                  mem_oe,
  input logic [CH_W-1:0]       red,
  input logic [CH_W-1:0]       green,
  input logic [CH_W-1:0]       blue
);

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (mem_addr == '0 && !mem_oe && red == '0 && green == '0 && blue == '0));

  a_r2_col_index: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> mem_addr[PIX_COORD_W-1:0] == PIX_COORD_W'($past(h_count) >> H_SHIFT));

  a_r3_row_index: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> mem_addr[ADDR_W-1:PIX_COORD_W] == PIX_COORD_W'($past(v_count) >> V_SHIFT));

  a_r4_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> mem_oe == ($past(h_active) && $past(v_active)));

  a_r5_colour_fields: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe |=> (red == $past(mem_rdata[5:4]) && green == $past(mem_rdata[3:2])
                && blue == $past(mem_rdata[1:0])));

  a_r6_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe |=> (red == '0 && green == '0 && blue == '0));

endmodule

bind lowres_pixel_fetch pf_checker #(
  .H_CNT_W (H_CNT_W),
  .V_CNT_W (V_CNT_W),
  .H_SHIFT (H_SHIFT),
  .V_SHIFT (V_SHIFT)
) u_pf_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .h_count   (h_count),
  .v_count   (v_count),
  .h_active  (h_active),
  .v_active  (v_active),
  .mem_rdata (mem_rdata),
  .mem_addr  (mem_addr),
  .mem_oe    (mem_oe),
  .red       (red),
  .green     (green),
  .blue      (blue)
);

// File: tb/tb_lowres_pixel_fetch.sv
`timescale 1ns/1ps
module tb_lowres_pixel_fetch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  h_count = '0;
  logic [9:0]  v_count = '0;
  logic        h_active = 1'b0;
  logic        v_active = 1'b0;
  logic [7:0]  mem_rdata;
  logic [13:0] mem_addr;
  logic        mem_oe;
  logic [1:0]  red, green, blue;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit top_bits_set = 1'b0;

  always #2.5 clk = ~clk;

  lowres_pixel_fetch dut (
    .clk (clk), .rst_n (rst_n), .h_count (h_count), .v_count (v_count),
    .h_active (h_active), .v_active (v_active), .mem_rdata (mem_rdata),
    .mem_addr (mem_addr), .mem_oe (mem_oe), .red (red), .green (green), .blue (blue)
  );

  // Image content computed from the address. An optional flag forces the two
  // unused top bits high. A disabled bus reads all ones.
  function automatic int img(input int a);
    int v;
    v = ((a * 29) ^ (a >> 5) ^ 8'h5A) & 255;
    if (top_bits_set) v = v | 8'hC0;
    else              v = v & 8'h3F;
    return v;
  endfunction

  assign mem_rdata = mem_oe ? 8'(img(int'(mem_addr))) : 8'hFF;

  function automatic int want_addr(input int h, input int v);
    return (v / 8) * 128 + (h / 2);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int h, input int v, input bit ha, input bit va);
    h_count  = 9'(h);
    v_count  = 10'(v);
    h_active = ha;
    v_active = va;
  endtask

  // Presents one position, checks address/enable after one edge and colour after two.
  task automatic probe(input int h, input int v, input bit ha, input bit va, input string req);
    int a, c;
    @(negedge clk); drive(h, v, ha, va);
    @(negedge clk);
    a = want_addr(h, v);
    chk({req, " addr"}, int'(mem_addr), a);
    chk({req, " oe"}, int'(mem_oe), int'(ha && va));
    @(negedge clk);
    c = (ha && va) ? (img(a) & 63) : 0;
    chk({req, " red"},   int'(red),   (c >> 4) & 3);
    chk({req, " green"}, int'(green), (c >> 2) & 3);
    chk({req, " blue"},  int'(blue),  c & 3);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    drive(37, 100, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    chk("R1 addr", int'(mem_addr), 0);
    chk("R1 oe", int'(mem_oe), 0);
    chk("R1 colour", int'({red, green, blue}), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_basic;
    probe(10, 40, 1'b1, 1'b1, "R2 R3 R5 mid");
    probe(151, 333, 1'b1, 1'b1, "R2 R3 R5 odd");
    probe(64, 200, 1'b1, 1'b1, "R5 second");
  endtask

  task automatic t_stretch;
    int a0;
    @(negedge clk); drive(84, 160, 1'b1, 1'b1);
    @(negedge clk); a0 = int'(mem_addr); drive(85, 167, 1'b1, 1'b1);
    @(negedge clk);
    chk("R7 pair and row band same addr", int'(mem_addr), a0);
    drive(86, 168, 1'b1, 1'b1);
    @(negedge clk);
    chk("R7 next band moves", int'(mem_addr), a0 + 128 + 1);
  endtask

  task automatic t_blank;
    probe(120, 300, 1'b0, 1'b1, "R4 R6 hblank");
    probe(120, 300, 1'b1, 1'b0, "R4 R6 vblank");
    probe(250, 610, 1'b0, 1'b0, "R4 R6 both");
  endtask

  task automatic t_top_bits;
    top_bits_set = 1'b1;
    probe(31, 77, 1'b1, 1'b1, "R5 top bits ignored");
    top_bits_set = 1'b0;
  endtask

  task automatic t_corners;
    probe(0, 0, 1'b1, 1'b1, "R8 origin");
    probe(199, 599, 1'b1, 1'b1, "R8 far corner");
    chk("R8 far corner value", want_addr(199, 599), 9571);
  endtask

  // Streams a line; active video ends partway through.
  task automatic t_stream;
    int pa1, pe1, pa2, pe2;
    pa1 = 0; pe1 = 0; pa2 = 0; pe2 = 0;
    @(negedge clk); drive(180, 424, 1'b1, 1'b1);
    pa1 = want_addr(180, 424); pe1 = 1;
    for (int i = 1; i < 30; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk("R9 stream colour", int'({red, green, blue}), pe2 ? (img(pa2) & 63) : 0);
      end
      chk("R9 stream addr", int'(mem_addr), pa1);
      chk("R9 stream oe", int'(mem_oe), pe1);
      pa2 = pa1; pe2 = pe1;
      drive(180 + i, 424, (180 + i) < 200, 1'b1);
      pa1 = want_addr(180 + i, 424); pe1 = int'((180 + i) < 200);
    end
  endtask

  initial begin
    t_reset;
    t_basic;
    t_stretch;
    t_blank;
    t_top_bits;
    t_corners;
    t_stream;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule